// File: doc/BRIEF.md
# Sixteen-Channel Prescaled Pulse-Width Modulator

This block produces sixteen pulse-width modulated outputs, each one set up by its own 32-bit word in a small register bank. Software writes and reads these words over a plain 32-bit register bus. The bus has a write strobe and a byte address, and read data is combinational. Each channel takes a tick from a shared free-running prescaler at one of eight fixed ratios. It stretches every tick by a 10-bit divider and uses the result to advance an 8-bit step counter. The output is the step counter compared against the channel's duty value, optionally inverted.

A channel with its enable bit clear drives a steady level equal to its polarity bit. Its counters are held at zero, so the next enable always starts a fresh period from step zero. The period of an enabled channel is ratio × (divider + 1) × 256 system clocks. The output is active for duty × ratio × (divider + 1) of those clocks.

Top module: `pwm_bank`

## Requirements
- R1: The word for channel i sits at byte address 4·i (address bits [5:2] pick the channel and bits [1:0] are ignored). A write stores all 32 bits, and reading that address returns the stored word in the same cycle the address is presented.
- R2: After reset every configuration word reads as zero and every output is low.
- R3: The word layout is: bit 31 enable, bits 30:28 prescaler code, bit 27 polarity, bits 17:8 divider, bits 7:0 duty. Bits 26:18 are stored but have no effect.
- R4: Prescaler codes 0 through 7 select tick ratios of 2, 4, 8, 64, 128, 1024, 2048 and 4096 system clocks.
- R5: With enable set and polarity 0, the output is high while the step count is below the duty value. Over any window of ratio × (divider + 1) × 256 clocks it is high for exactly duty × ratio × (divider + 1) clocks.
- R6: Polarity 1 inverts the output of an enabled channel.
- R7: With enable clear, the output is held at the polarity bit.
- R8: Duty 0 with polarity 0 gives an output that never goes high.
- R9: Clearing the enable bit returns the channel's divider and step counters to zero. A later enable with nonzero duty shows a high output (polarity 0) in the first cycle after the write.
- R10: All channels share one prescaler counter that counts every clock from zero after reset. A channel with ratio 2^k advances its divider only on clocks where the low k bits of that counter are all ones, so outputs change only on such clocks or after a write.
- R11: A write alters the addressed channel's output from the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Byte address; bits [5:2] pick the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Word stored at the presented address |
| pwm_out | output | 16 | One modulated output per channel |

## Verification
A register write can land on the very clock edge where the same channel's prescaler tick rolls its divider over or advances its step counter. Examples are a disable arriving on a step, or a new divider smaller than the running divider count. The bench provokes this by rewriting channels at many prescaler phases while a behavioural model tracks every counter. It compares all sixteen outputs against that model on every clock, so the write and the tick must resolve in the order the requirements give.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;

   localparam int CFG_W      = 32;
   localparam int SEL_W      = 3;
   localparam int DIV_W      = 10;
   localparam int DUTY_W     = 8;
   localparam int SPARE_W    = CFG_W - 1 - SEL_W - 1 - DIV_W - DUTY_W;
   localparam int NUM_RATIOS = 1 << SEL_W;
   localparam int MAX_SHIFT  = 12;

   typedef struct packed {
      logic               en;
      logic [SEL_W-1:0]   sel;
      logic               pol;
      logic [SPARE_W-1:0] spare;
      logic [DIV_W-1:0]   div;
      logic [DUTY_W-1:0]  duty;
   } chan_cfg_t;

   // log2 of the tick ratio selected by each prescaler code
   function automatic int ratio_shift(input int code);
      case (code)
         0:       return 1;
         1:       return 2;
         2:       return 3;
         3:       return 6;
         4:       return 7;
         5:       return 10;
         6:       return 11;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
`timescale 1ns/1ps
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int IDX_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IDX_W-1:0]        idx,
   input  logic [CFG_W-1:0]        wdata,
   output logic [CFG_W-1:0]        rdata,
   output chan_cfg_t [NUM_CH-1:0]  cfg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (idx == IDX_W'(i)) begin
               cfg_q[i] <= chan_cfg_t'(wdata);
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (idx == IDX_W'(i)) begin
            rdata = CFG_W'(cfg_q[i]);
         end
      end
   end

endmodule

// File: rtl/pwm_bank_prescale.sv
`timescale 1ns/1ps
module pwm_bank_prescale
   import pwm_bank_pkg::*;
#(
   parameter int PRE_W = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic [PRE_W-1:0]      cnt_q,
   output logic [NUM_RATIOS-1:0] tick
);

   generate
      if (PRE_W < MAX_SHIFT) begin : g_bad_width
         $error("pwm_bank_prescale: PRE_W must cover the largest ratio");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_tick
      localparam int SH = ratio_shift(k);
      assign tick[k] = &cnt_q[SH-1:0];
   end

endmodule

// File: rtl/pwm_bank_chan.sv
`timescale 1ns/1ps
module pwm_bank_chan
   import pwm_bank_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [SEL_W-1:0]      sel,
   input  logic                  pol,
   input  logic [DIV_W-1:0]      div,
   input  logic [DUTY_W-1:0]     duty,
   input  logic [NUM_RATIOS-1:0] tick,
   output logic                  pwm_o
);

   logic [DIV_W-1:0]  div_q;
   logic [DUTY_W-1:0] step_q;
   logic              adv;
   logic              active;

   assign adv = tick[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         step_q <= '0;
      end else if (!en) begin
         div_q  <= '0;
         step_q <= '0;
      end else if (adv) begin
         if (div_q >= div) begin
            div_q  <= '0;
            step_q <= step_q + 1'b1;
         end else begin
            div_q  <= div_q + 1'b1;
         end
      end
   end

   assign active = (step_q < duty);
   assign pwm_o  = en ? (active ^ pol) : pol;

endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int ADDR_W = 6,
   parameter int PRE_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int IDX_W = ADDR_W - 2;

   generate
      if (NUM_CH < 1 || NUM_CH > (1 << IDX_W)) begin : g_bad_ch
         $error("pwm_bank: NUM_CH does not fit the address range");
      end
   endgenerate

   chan_cfg_t [NUM_CH-1:0]  cfg_q;
   logic [PRE_W-1:0]        pre_cnt;
   logic [NUM_RATIOS-1:0]   pre_tick;

   pwm_bank_regs #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we),
      .idx   (bus_addr[ADDR_W-1:2]),
      .wdata (bus_wdata),
      .rdata (bus_rdata),
      .cfg_q (cfg_q)
   );

   pwm_bank_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_q (pre_cnt),
      .tick  (pre_tick)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pwm_bank_chan u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (cfg_q[c].en),
         .sel   (cfg_q[c].sel),
         .pol   (cfg_q[c].pol),
         .div   (cfg_q[c].div),
         .duty  (cfg_q[c].duty),
         .tick  (pre_tick),
         .pwm_o (pwm_out[c])
      );
   end

endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
module pwm_bank_chk #(
   parameter int NUM_CH = 16,
   parameter int ADDR_W = 6,
   parameter int PRE_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [NUM_CH-1:0] pwm_out,
   input logic [PRE_W-1:0]  pre_cnt
);

   logic armed;
   logic in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign in_range = int'(bus_addr[ADDR_W-1:2]) < NUM_CH;

   AST_READBACK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && in_range) |=> (!$stable(bus_addr) || bus_rdata == $past(bus_wdata))); // R1

   AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && in_range && !bus_wdata[31])
      |=> pwm_out[$past(bus_addr[ADDR_W-1:2])] == $past(bus_wdata[27])); // R7

   AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && in_range && bus_wdata[31] && !bus_wdata[27] && bus_wdata[7:0] == 8'd0)
      |=> !pwm_out[$past(bus_addr[ADDR_W-1:2])]); // R8

   AST_PRESCALE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> pre_cnt == $past(pre_cnt) + 1'b1); // R10

   AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && !pre_cnt[0]) |=> $stable(pwm_out)); // R10

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PRE_W(PRE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pwm_out   (pwm_out),
   .pre_cnt   (pre_cnt)
);

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_bank u_pwm_bank (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_cfg [16];
   int          m_div [16];
   int          m_step[16];
   int          m_pre;

   function automatic int ratio_of(input logic [2:0] code);
      case (code)
         3'd0: return 2;    3'd1: return 4;    3'd2: return 8;    3'd3: return 64;
         3'd4: return 128;  3'd5: return 1024; 3'd6: return 2048; default: return 4096;
      endcase
   endfunction

   function automatic logic [31:0] mk(input bit en, input int sel, input bit pol,
                                      input int dv, input int duty);
      return {en, 3'(sel), pol, 9'd0, 10'(dv), 8'(duty)};
   endfunction

   function automatic logic [15:0] model_out();
      logic [15:0] o;
      for (int c = 0; c < 16; c++) begin
         if (!m_cfg[c][31]) o[c] = m_cfg[c][27];
         else o[c] = (m_step[c] < int'(m_cfg[c][7:0])) ^ m_cfg[c][27];
      end
      return o;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0;
         for (int c = 0; c < 16; c++) begin
            m_cfg[c] = '0; m_div[c] = 0; m_step[c] = 0;
         end
      end else begin
         for (int c = 0; c < 16; c++) begin
            if (!m_cfg[c][31]) begin
               m_div[c] = 0; m_step[c] = 0;
            end else if ((m_pre % ratio_of(m_cfg[c][30:28])) == ratio_of(m_cfg[c][30:28]) - 1) begin
               if (m_div[c] >= int'(m_cfg[c][17:8])) begin
                  m_div[c] = 0;
                  m_step[c] = (m_step[c] + 1) % 256;
               end else begin
                  m_div[c] = m_div[c] + 1;
               end
            end
         end
         if (bus_we) m_cfg[bus_addr[5:2]] = bus_wdata;
         m_pre = (m_pre + 1) % 4096;
      end
   end

   // R10 R4: every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (pwm_out !== model_out()) begin
            errors++;
            $display("FAIL R10 per-clock model: act %h exp %h", pwm_out, model_out());
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act %0d exp %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int ch, input logic [31:0] w);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 6'(ch * 4); bus_wdata = w;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input int ch, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = 6'(ch * 4 + 2);
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s readback ch%0d act %h exp %h", tag, ch, bus_rdata, exp);
      end
   endtask

   task automatic summary();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act 0 exp 1");
      summary();
   end

   // ---------------- stimulus ----------------
   initial begin
      int hi3, lo4, hi5, hi7, t;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pwm_out == 16'h0, "R2 outputs low", int'(pwm_out), 0);
      rd_chk(0, 32'h0, "R2");
      rd_chk(15, 32'h0, "R2");

      // R1 R3: placement and full-word storage
      wr(0, 32'h0ABC_DE12);
      wr(15, 32'h0155_0203);
      rd_chk(0, 32'h0ABC_DE12, "R1");
      rd_chk(15, 32'h0155_0203, "R1");
      // R7 R11: disabled, polarity bit 27 = 1 in channel 0 word
      chk(pwm_out[0] == 1'b1, "R7 disabled level", int'(pwm_out[0]), 1);

      wr(1, mk(0, 0, 1, 0, 0));
      chk(pwm_out[1] == 1'b1, "R11 next-cycle effect", int'(pwm_out[1]), 1);
      t = 0;
      repeat (50) begin @(negedge clk); if (!pwm_out[1]) t++; end
      chk(t == 0, "R7 steady high", t, 0);

      // R8: duty 0
      wr(2, mk(1, 0, 0, 0, 0));
      t = 0;
      repeat (600) begin @(negedge clk); if (pwm_out[2]) t++; end
      chk(t == 0, "R8 never high", t, 0);

      // R5 R6 R3: duty windows
      wr(3, mk(1, 0, 0, 1, 64));     // period 1024, high 256
      wr(4, mk(1, 0, 1, 0, 200));    // period 512, low 400
      wr(5, mk(1, 3, 0, 0, 128));    // period 16384, high 8192
      wr(7, mk(1, 1, 0, 3, 128));    // period 4096, high 2048
      rd_chk(7, mk(1, 1, 0, 3, 128), "R3");
      hi3 = 0; lo4 = 0; hi5 = 0; hi7 = 0;
      repeat (16384) begin
         @(negedge clk);
         if (pwm_out[3]) hi3++;
         if (!pwm_out[4]) lo4++;
         if (pwm_out[5]) hi5++;
         if (pwm_out[7]) hi7++;
      end
      chk(hi3 == 4096, "R5 ch3 high clocks", hi3, 4096);
      chk(lo4 == 12800, "R6 ch4 low clocks", lo4, 12800);
      chk(hi5 == 8192, "R5 ch5 high clocks", hi5, 8192);
      chk(hi7 == 8192, "R3 ch7 high clocks", hi7, 8192);

      // R9: disable clears counters, re-enable restarts high
      wr(6, mk(1, 0, 0, 0, 100));
      repeat (300) @(negedge clk);
      chk(pwm_out[6] == 1'b0, "R5 past duty low", int'(pwm_out[6]), 0);
      wr(6, mk(0, 0, 0, 0, 100));
      chk(pwm_out[6] == 1'b0, "R7 disabled low", int'(pwm_out[6]), 0);
      wr(6, mk(1, 0, 0, 0, 100));
      chk(pwm_out[6] == 1'b1, "R9 restart high", int'(pwm_out[6]), 1);

      // divider shrink while running, checked by the model
      wr(3, mk(1, 0, 0, 0, 64));
      repeat (37) @(negedge clk);
      wr(3, mk(1, 2, 0, 5, 30));
      wr(3, mk(1, 2, 0, 1, 30));

      // R4: all eight ratios, duty 1
      for (int c = 8; c < 15; c++) wr(c, mk(1, c - 8, 0, 0, 1));
      wr(15, mk(1, 7, 0, 0, 1));
      t = 0;
      while (pwm_out[15] && t < 5000) begin @(negedge clk); t++; end
      chk(t >= 1 && t <= 4096, "R4 ratio 4096 first step", t, 4096);
      repeat (9000) @(negedge clk);
      rd_chk(12, mk(1, 4, 0, 0, 1), "R1");

      summary();
   end

endmodule